// File: doc/BRIEF.md
# Halt and Stop Grant Event Controller

This block sits on the processor side of a system bus and owns the low-power idle states of a core: a plain Halt state and a deeper Stop Grant state in which the caches are powered down. While the core idles, sampled event inputs arrive. They are reset, init, maskable and non-maskable interrupts, system-management interrupt, cache flush, stop-clock, external snoop, bus-init, hard-fail and functional-redundancy error. For each one the controller chooses an immediate action code and decides whether the core comes back to Halt or resumes running.

Some events need a special bus transaction: Sync, Flush Acknowledge, Stop Grant Acknowledge or SMI Acknowledge. The controller raises a request with a two-bit type code and holds it until the bus logic answers with a ready pulse. Every request also carries a system-management memory qualifier. This bit turns on with the acknowledge that enters the management handler and turns off with the acknowledge that leaves it. Snoops are answered in parallel with everything else. The answer comes later when the caches are powered down.

Top module: `halt_event_ctrl`

## Requirements
- R1: After rst_n is released, halted, stop_grant, txn_req, txn_smm, act_valid and snoop_resp are all 0, and the core is running.
- R2: While running, halt_cmd enters Halt at the next edge. wbinvd_cmd waits for cache_done and then requests type 0 (Sync), and the core keeps running after ready.
- R3: In Halt, ev_intr gives action code 1 and ev_nmi gives action code 2. Both leave Halt and the core stays running.
- R4: In Halt, ev_reset or ev_init gives action code 3, leaves Halt and clears the management qualifier.
- R5: In Halt, ev_businit, ev_hardfail or ev_frcerr gives action code 5 (machine check) and leaves Halt.
- R6: ev_flush waits for cache_done and then requests type 1 (Flush Acknowledge). After ready the controller goes back to the state the flush came from: Halt or Stop Grant.
- R7: In Halt, ev_stopclk requests type 2 (Stop Grant Acknowledge), and stop_grant rises after ready. Stop Grant goes back to Halt at the first edge where ev_stopclk is low.
- R8: In Stop Grant only ev_reset, ev_businit, ev_flush and ev_snoop are acted on. ev_init, ev_smi, ev_nmi, ev_intr, ev_hardfail and ev_frcerr produce no action and no request, and stop_grant stays set.
- R9: In Halt outside management mode, ev_smi gives action code 4 and requests type 3 with txn_smm=1. Every request stays qualified until rsm, which requests type 3 with txn_smm=0. After ready the core goes back to Halt if smm_halt_cfg is 1 and keeps running if it is 0. An SMI that arrives during management mode is ignored.
- R10: When Halt-state events arrive together, only the highest one is taken, in this order: reset, init, machine check, flush, SMI, NMI, stop-clock, interrupt.
- R11: snoop_resp pulses for one cycle, 1 cycle after an ev_snoop strobe, or SNOOP_DLY cycles after it when the strobe arrives in Stop Grant.
- R12: A request, with its type and qualifier, stays stable until txn_rdy is seen, and only one request is outstanding at a time. act_valid is high for one cycle together with the action code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the controller |
| halt_cmd | input | 1 | Core executes a halt |
| wbinvd_cmd | input | 1 | Core requests write-back-and-invalidate |
| cache_done | input | 1 | Cache write-back/invalidate finished |
| rsm | input | 1 | Return from management handler |
| smm_halt_cfg | input | 1 | Go back to Halt after rsm |
| ev_intr | input | 1 | Maskable interrupt |
| ev_nmi | input | 1 | Non-maskable interrupt |
| ev_init | input | 1 | Init event |
| ev_reset | input | 1 | Reset event |
| ev_stopclk | input | 1 | Stop-clock level |
| ev_smi | input | 1 | Management interrupt |
| ev_flush | input | 1 | Cache flush request |
| ev_snoop | input | 1 | External snoop strobe |
| ev_businit | input | 1 | Bus-init error |
| ev_hardfail | input | 1 | Hard-fail error |
| ev_frcerr | input | 1 | Redundancy-check error |
| txn_rdy | input | 1 | Bus accepted the request |
| txn_req | output | 1 | Special transaction request |
| txn_type | output | 2 | 0 Sync, 1 Flush Ack, 2 Stop Grant Ack, 3 SMI Ack |
| txn_smm | output | 1 | Management memory qualifier on the request |
| act_valid | output | 1 | Action code valid pulse |
| act_code | output | 3 | 1 intr, 2 NMI, 3 reset handler, 4 SMI, 5 machine check |
| halted | output | 1 | Core is in Halt |
| stop_grant | output | 1 | Core is in Stop Grant |
| snoop_resp | output | 1 | Snoop result pulse |

## Verification
The bench applies all 255 non-empty combinations of the eight prioritised events in Halt. A design with a wrong priority would report the wrong action code or issue a request that should not exist. Each of the six events that Stop Grant must ignore is pulsed there. A design that let one through would raise act_valid or drop stop_grant. The bench also checks the qualifier on requests issued inside management mode and on both acknowledges, where an off-by-one framing would show the wrong txn_smm. It measures snoop latency in both modes, so a design that did not delay the answer in Stop Grant would answer early.

// File: rtl/halt_event_ctrl.sv
module halt_event_ctrl #(
  parameter int SNOOP_DLY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_cmd,
  input  logic       wbinvd_cmd,
  input  logic       cache_done,
  input  logic       rsm,
  input  logic       smm_halt_cfg,
  input  logic       ev_intr,
  input  logic       ev_nmi,
  input  logic       ev_init,
  input  logic       ev_reset,
  input  logic       ev_stopclk,
  input  logic       ev_smi,
  input  logic       ev_flush,
  input  logic       ev_snoop,
  input  logic       ev_businit,
  input  logic       ev_hardfail,
  input  logic       ev_frcerr,
  input  logic       txn_rdy,
  output logic       txn_req,
  output logic [1:0] txn_type,
  output logic       txn_smm,
  output logic       act_valid,
  output logic [2:0] act_code,
  output logic       halted,
  output logic       stop_grant,
  output logic       snoop_resp
);
  localparam int CW = $clog2(SNOOP_DLY + 1);
  localparam logic [1:0] T_SYNC = 2'd0, T_FACK = 2'd1, T_SGACK = 2'd2, T_SMIACK = 2'd3;
  localparam logic [2:0] A_NONE = 3'd0, A_INTR = 3'd1, A_NMI = 3'd2, A_RST = 3'd3,
                         A_SMI = 3'd4, A_MCA = 3'd5;

  typedef enum logic [2:0] {S_RUN, S_HALT, S_SGNT, S_CWAIT, S_TXN} st_t;

  st_t         st, post_st;
  logic        cw_sync, ret_sg, smm_q;
  logic [1:0]  ttype_q;
  logic [2:0]  act_q;
  logic [CW-1:0] snp_cnt;

  assign txn_req    = (st == S_TXN);
  assign txn_type   = ttype_q;
  assign txn_smm    = smm_q;
  assign act_code   = act_q;
  assign act_valid  = (act_q != A_NONE);
  assign halted     = (st == S_HALT);
  assign stop_grant = (st == S_SGNT);
  assign snoop_resp = (snp_cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      post_st <= S_RUN;
      cw_sync <= 1'b0;
      ret_sg  <= 1'b0;
      smm_q   <= 1'b0;
      ttype_q <= T_SYNC;
      act_q   <= A_NONE;
      snp_cnt <= '0;
    end else begin
      act_q <= A_NONE;
      if (ev_snoop)
        snp_cnt <= (st == S_SGNT) ? CW'(SNOOP_DLY) : CW'(1);
      else if (snp_cnt != '0)
        snp_cnt <= snp_cnt - CW'(1);

      case (st)
        S_RUN: begin
          if (smm_q && rsm) begin
            st <= S_TXN; ttype_q <= T_SMIACK; smm_q <= 1'b0;
            post_st <= smm_halt_cfg ? S_HALT : S_RUN;
          end else if (wbinvd_cmd) begin
            st <= S_CWAIT; cw_sync <= 1'b1;
          end else if (halt_cmd) begin
            st <= S_HALT;
          end
        end
        S_HALT: begin
          if (ev_reset || ev_init) begin
            act_q <= A_RST; smm_q <= 1'b0; st <= S_RUN;
          end else if (ev_businit || ev_hardfail || ev_frcerr) begin
            act_q <= A_MCA; st <= S_RUN;
          end else if (ev_flush) begin
            st <= S_CWAIT; cw_sync <= 1'b0; ret_sg <= 1'b0;
          end else if (ev_smi && !smm_q) begin
            act_q <= A_SMI; smm_q <= 1'b1;
            st <= S_TXN; ttype_q <= T_SMIACK; post_st <= S_RUN;
          end else if (ev_nmi) begin
            act_q <= A_NMI; st <= S_RUN;
          end else if (ev_stopclk) begin
            st <= S_TXN; ttype_q <= T_SGACK; post_st <= S_SGNT;
          end else if (ev_intr) begin
            act_q <= A_INTR; st <= S_RUN;
          end
        end
        S_SGNT: begin
          if (ev_reset) begin
            act_q <= A_RST; smm_q <= 1'b0; st <= S_RUN;
          end else if (ev_businit) begin
            act_q <= A_MCA; st <= S_RUN;
          end else if (ev_flush) begin
            st <= S_CWAIT; cw_sync <= 1'b0; ret_sg <= 1'b1;
          end else if (!ev_stopclk) begin
            st <= S_HALT;
          end
        end
        S_CWAIT: begin
          if (cache_done) begin
            st      <= S_TXN;
            ttype_q <= cw_sync ? T_SYNC : T_FACK;
            post_st <= cw_sync ? S_RUN : (ret_sg ? S_SGNT : S_HALT);
          end
        end
        S_TXN: if (txn_rdy) st <= post_st;
        default: st <= S_RUN;
      endcase
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req && !txn_rdy |=> txn_req && $stable(txn_type) && $stable(txn_smm));

  p_qual_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txn_smm) |-> (txn_req && txn_type == T_SMIACK) || act_code == A_RST);

  p_sg_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_grant) |-> $past(txn_req && txn_rdy && txn_type == T_SGACK) || $past(txn_req && txn_rdy && txn_type == T_FACK));

  p_sg_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_grant) && halted |-> !$past(ev_stopclk));

  p_mca_nohalt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_code == A_MCA |-> !halted && !stop_grant);

  p_sg_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_grant && !ev_reset && !ev_businit |=> !act_valid);

  p_snoop_fast_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_snoop && !stop_grant |=> snoop_resp);
endmodule

// File: tb/halt_event_ctrl_tb.sv
module halt_event_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_cmd = 0, wbinvd_cmd = 0, cache_done = 0, rsm = 0, smm_halt_cfg = 1;
  logic ev_intr = 0, ev_nmi = 0, ev_init = 0, ev_reset = 0, ev_stopclk = 0, ev_smi = 0;
  logic ev_flush = 0, ev_snoop = 0, ev_businit = 0, ev_hardfail = 0, ev_frcerr = 0;
  logic txn_rdy = 0;
  logic txn_req, txn_smm, act_valid, halted, stop_grant, snoop_resp;
  logic [1:0] txn_type;
  logic [2:0] act_code;
  int checks = 0, errors = 0;
  localparam int DLY = 4;

  always #10 clk = ~clk;

  halt_event_ctrl #(.SNOOP_DLY(DLY)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask
  task automatic handshake; txn_rdy = 1; tick; txn_rdy = 0; endtask
  task automatic go_halt; halt_cmd = 1; tick; halt_cmd = 0; endtask

  task automatic set_ev(input logic [7:0] p);
    {ev_intr, ev_stopclk, ev_nmi, ev_smi, ev_flush, ev_businit, ev_init, ev_reset} = p;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick; tick;
    rst_n = 1;
    tick;
    chk("R1 halted", halted, 0); chk("R1 stop_grant", stop_grant, 0);
    chk("R1 txn_req", txn_req, 0); chk("R1 txn_smm", txn_smm, 0);
    chk("R1 act_valid", act_valid, 0); chk("R1 snoop_resp", snoop_resp, 0);

    wbinvd_cmd = 1; tick; wbinvd_cmd = 0;
    chk("R2 no early sync", txn_req, 0);
    tick; chk("R2 waits cache", txn_req, 0);
    cache_done = 1; tick; cache_done = 0;
    chk("R2 sync req", txn_req, 1); chk("R2 sync type", txn_type, 0);
    tick; chk("R12 req held", txn_req, 1); chk("R12 type held", txn_type, 0);
    handshake;
    chk("R2 req dropped", txn_req, 0); chk("R2 running", halted, 0);
    go_halt; chk("R2 halt entry", halted, 1);

    // R10 sweep: bit0 reset,1 init,2 businit,3 flush,4 smi,5 nmi,6 stopclk,7 intr
    for (int p = 1; p < 256; p++) begin
      int w;
      w = 0;
      while (((p >> w) & 1) == 0) w++;
      set_ev(p[7:0]); tick; set_ev(8'd0);
      case (w)
        0, 1: begin chk("R10 R4 act", act_code, 3); chk("R4 left halt", halted, 0); chk("R10 no req", txn_req, 0); go_halt; end
        2: begin chk("R10 R5 act", act_code, 5); chk("R5 left halt", halted, 0); chk("R10 no req", txn_req, 0); go_halt; end
        5: begin chk("R10 R3 nmi act", act_code, 2); chk("R3 left halt", halted, 0); go_halt; end
        7: begin chk("R10 R3 intr act", act_code, 1); chk("R3 left halt", halted, 0); go_halt; end
        3: begin
          chk("R10 R6 no act", act_valid, 0); chk("R6 waits cache", txn_req, 0);
          cache_done = 1; tick; cache_done = 0;
          chk("R6 fack type", txn_type, 1); chk("R6 fack req", txn_req, 1);
          handshake; chk("R6 back to halt", halted, 1);
        end
        4: begin
          chk("R10 R9 smi act", act_code, 4); chk("R9 entry type", txn_type, 3);
          chk("R9 entry qual", txn_smm, 1);
          handshake; chk("R9 running", halted, 0);
          rsm = 1; smm_halt_cfg = 1; tick; rsm = 0;
          chk("R9 exit type", txn_type, 3); chk("R9 exit qual", txn_smm, 0);
          handshake; chk("R9 cfg halt", halted, 1);
        end
        default: begin
          chk("R10 R7 no act", act_valid, 0); chk("R7 sgack type", txn_type, 2);
          handshake; chk("R7 stop grant", stop_grant, 1);
          tick; chk("R7 back to halt", halted, 1);
        end
      endcase
    end

    // Snoop latency
    ev_snoop = 1; tick; ev_snoop = 0;
    chk("R11 fast snoop", snoop_resp, 1);
    tick; chk("R11 single pulse", snoop_resp, 0);

    // Enter stop grant and keep stopclk asserted
    ev_stopclk = 1; tick; handshake;
    chk("R7 stop grant held", stop_grant, 1);
    ev_snoop = 1; tick; ev_snoop = 0;
    for (int i = 1; i < DLY; i++) begin
      chk("R11 delayed low", snoop_resp, 0); tick;
    end
    chk("R11 delayed high", snoop_resp, 1);
    tick; chk("R11 delayed single", snoop_resp, 0);

    // R8 ignored events in stop grant
    for (int e = 0; e < 6; e++) begin
      case (e)
        0: ev_init = 1; 1: ev_smi = 1; 2: ev_nmi = 1;
        3: ev_intr = 1; 4: ev_hardfail = 1; default: ev_frcerr = 1;
      endcase
      tick;
      {ev_init, ev_smi, ev_nmi, ev_intr, ev_hardfail, ev_frcerr} = '0;
      chk("R8 no action", act_valid, 0); chk("R8 no request", txn_req, 0);
      chk("R8 stays stop grant", stop_grant, 1);
    end

    // R6 flush from stop grant returns there
    ev_flush = 1; tick; ev_flush = 0;
    chk("R6 sg left for flush", stop_grant, 0);
    cache_done = 1; tick; cache_done = 0;
    chk("R6 sg fack type", txn_type, 1);
    handshake; chk("R6 back to stop grant", stop_grant, 1);

    // R8 businit acts in stop grant
    ev_businit = 1; tick; ev_businit = 0;
    chk("R8 businit act", act_code, 5); chk("R8 left stop grant", stop_grant, 0);
    go_halt; ev_stopclk = 1; tick; handshake;
    ev_reset = 1; tick; ev_reset = 0;
    chk("R8 reset act", act_code, 3); chk("R8 reset leaves sg", stop_grant, 0);
    ev_stopclk = 0;

    // SMM qualifier on a sync, SMI ignored inside SMM, init clears qualifier
    go_halt; ev_smi = 1; tick; ev_smi = 0; handshake;
    wbinvd_cmd = 1; tick; wbinvd_cmd = 0; cache_done = 1; tick; cache_done = 0;
    chk("R9 sync qualified", txn_smm, 1); chk("R9 sync type", txn_type, 0);
    handshake;
    go_halt; ev_smi = 1; tick; ev_smi = 0;
    chk("R9 nested smi ignored", act_valid, 0); chk("R9 still halted", halted, 1);
    ev_init = 1; tick; ev_init = 0;
    chk("R4 init act", act_code, 3); chk("R4 qual cleared", txn_smm, 0);

    // R9 exit with cfg=0 keeps running
    go_halt; ev_smi = 1; tick; ev_smi = 0; handshake;
    smm_halt_cfg = 0; rsm = 1; tick; rsm = 0;
    chk("R9 exit qual cfg0", txn_smm, 0);
    handshake; tick;
    chk("R9 cfg0 running", halted, 0); chk("R9 cfg0 no req", txn_req, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule